// File: doc/BRIEF.md
# Four-Phase Bundled-Data Word Link

This block carries words from a producer to a consumer across a request/acknowledge channel that follows a four-phase, return-to-zero handshake. It has a sending endpoint and a receiving endpoint, both modelled in clocked logic that runs from one sampling clock. On the producer side a word enters through a valid/ready port. The sender places it on a data bus with one wire per bit, waits a configurable settling time, and then raises the request line. The receiver captures the word, raises acknowledge and offers the word on a valid/ready output port. Request then falls, acknowledge falls, and the channel is idle again.

Each transfer leaves both channel lines low. No phase state has to be kept from one word to the next. The bundling delay models the time the data wires need to settle before request may announce them. Delay values of zero are rounded up to one cycle. The channel lines and the data bus are also brought out as outputs so that their timing can be observed.

Top module: `bdlLink`

## Requirements
- R1: During reset and right after it, reqLine, ackLine and outValid are 0 and inReady is 1.
- R2: inReady is 1 only while the sender is idle, with reqLine and ackLine both low. A word is taken on a clock edge where inValid and inReady are both 1. After the handshake completes, inReady returns to 1 exactly one cycle after ackLine falls.
- R3: reqLine rises exactly N clock edges after the edge that loads the word onto busData. N equals dlyCfg sampled at acceptance, and a dlyCfg of 0 gives N = 1.
- R4: busData holds the accepted word and does not change from the load until the next word is accepted. In particular, it is stable in every cycle in which reqLine is high.
- R5: Only the sender drives reqLine. reqLine never rises while ackLine is high, and it falls on the edge after the sender samples ackLine high.
- R6: Only the receiver drives ackLine. The receiver registers busData on the edge where it samples reqLine high with its output slot free, and it raises ackLine on the following edge.
- R7: ackLine falls on the edge after the receiver samples reqLine low. By the end of every transfer, both lines are low.
- R8: Words appear on outData in the order they were sent and with unchanged values. While outValid is 1 and outReady is 0, outValid and outData hold.
- R9: While a received word waits on the output port, the receiver does not respond to a new request. ackLine stays low and reqLine stays high until the word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Producer offers a word |
| inReady | output | 1 | Sender idle and able to take a word |
| inData | input | DATA_W | Word from the producer |
| dlyCfg | input | DLY_W | Bundling delay in cycles (0 treated as 1) |
| outValid | output | 1 | Received word available |
| outReady | input | 1 | Consumer takes the word |
| outData | output | DATA_W | Received word |
| reqLine | output | 1 | Channel request level, driven by the sender |
| ackLine | output | 1 | Channel acknowledge level, driven by the receiver |
| busData | output | DATA_W | Channel data wires, driven by the sender |

## Verification
The hardest state to reach is a stalled channel. In that state request stays high with acknowledge low because the receiver still holds an undelivered word, and the sender must keep the bus frozen. To reach it, the stimulus holds outReady low and sends two words back to back. Once the channel has sat in that state for a while, outReady is released and the stalled word must still arrive intact. A second corner is the bundling delay at its limits: a setting of zero, of one and of the maximum. Each one is timed edge by edge from acceptance to the rise of request.

// File: rtl/bdlPkg.sv
package bdlPkg;

  typedef enum logic [1:0] {
    SND_IDLE  = 2'd0,
    SND_SETUP = 2'd1,
    SND_REQ   = 2'd2,
    SND_REL   = 2'd3
  } sendStateT;

  typedef enum logic [1:0] {
    RCV_IDLE = 2'd0,
    RCV_CAPT = 2'd1,
    RCV_ACK  = 2'd2
  } recvStateT;

  typedef struct packed {
    logic loadWord;
  } sendStrobeT;

endpackage

// File: rtl/bdlSendCtrl.sv
module bdlSendCtrl
  import bdlPkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [DLY_W-1:0] dlyCfg,
  input  logic             ackIn,
  output logic             reqOut,
  output sendStrobeT       strobe
);

  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  sendStateT        state;
  logic [DLY_W-1:0] dlyCnt;
  logic             takeWord;

  assign inReady         = (state == SND_IDLE);
  assign takeWord        = inReady && inValid;
  assign strobe.loadWord = takeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SND_IDLE;
      dlyCnt <= '0;
      reqOut <= 1'b0;
    end else begin
      unique case (state)
        SND_IDLE: begin
          if (takeWord) begin
            dlyCnt <= (dlyCfg == '0) ? DLY_ONE : dlyCfg;
            state  <= SND_SETUP;
          end
        end
        SND_SETUP: begin
          if (dlyCnt == DLY_ONE) begin
            reqOut <= 1'b1;
            state  <= SND_REQ;
          end else begin
            dlyCnt <= dlyCnt - DLY_ONE;
          end
        end
        SND_REQ: begin
          if (ackIn) begin
            reqOut <= 1'b0;
            state  <= SND_REL;
          end
        end
        SND_REL: begin
          if (!ackIn) state <= SND_IDLE;
        end
        default: state <= SND_IDLE;
      endcase
    end
  end

  AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqOut) |-> !ackIn); // R5
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqOut) |-> $past(ackIn)); // R5
  AST_READY_LINES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!reqOut && !ackIn)); // R2

endmodule

// File: rtl/bdlSendPath.sv
module bdlSendPath
  import bdlPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sendStrobeT        strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] busData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData <= '0;
    end else if (strobe.loadWord) begin
      busData <= inData;
    end
  end

endmodule

// File: rtl/bdlRecv.sv
module bdlRecv
  import bdlPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  input  logic [DATA_W-1:0] busIn,
  output logic              ackOut,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  recvStateT state;
  logic      capture;

  assign capture = (state == RCV_IDLE) && reqIn && !outValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RCV_IDLE;
      ackOut   <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (capture) begin
        outData  <= busIn;
        outValid <= 1'b1;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
      unique case (state)
        RCV_IDLE: if (capture) state <= RCV_CAPT;
        RCV_CAPT: begin
          ackOut <= 1'b1;
          state  <= RCV_ACK;
        end
        RCV_ACK: begin
          if (!reqIn) begin
            ackOut <= 1'b0;
            state  <= RCV_IDLE;
          end
        end
        default: state <= RCV_IDLE;
      endcase
    end
  end

  AST_BUS_STABLE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn && $past(reqIn)) |-> $stable(busIn)); // R4
  AST_ACK_RISE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(reqIn)); // R6
  AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> !$past(reqIn)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8

endmodule

// File: rtl/bdlLink.sv
module bdlLink
  import bdlPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [DLY_W-1:0]  dlyCfg,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              reqLine,
  output logic              ackLine,
  output logic [DATA_W-1:0] busData
);

  sendStrobeT sendStb;

  bdlSendCtrl #(.DLY_W(DLY_W)) u_sendCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .dlyCfg(dlyCfg), .ackIn(ackLine), .reqOut(reqLine), .strobe(sendStb)
  );

  bdlSendPath #(.DATA_W(DATA_W)) u_sendPath (
    .clk(clk), .rstN(rstN), .strobe(sendStb), .inData(inData), .busData(busData)
  );

  bdlRecv #(.DATA_W(DATA_W)) u_recv (
    .clk(clk), .rstN(rstN), .reqIn(reqLine), .busIn(busData), .ackOut(ackLine),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

endmodule

// File: tb/bdlLink_bench.sv
`timescale 1ns/1ps
module bdlLink_bench;

  localparam int DATA_W = 16;
  localparam int DLY_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic [DLY_W-1:0]  dlyCfg = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [DATA_W-1:0] outData;
  logic              reqLine;
  logic              ackLine;
  logic [DATA_W-1:0] busData;

  int checks = 0;
  int errors = 0;
  int consumerMode = 0; // 0 always ready, 1 random, 2 never
  logic [DATA_W-1:0] sbq[$];

  always #4 clk = ~clk;

  bdlLink #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_bdlLink (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .dlyCfg(dlyCfg), .outValid(outValid), .outReady(outReady), .outData(outData),
    .reqLine(reqLine), .ackLine(ackLine), .busData(busData)
  );

  function automatic int expDelay(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // consumer and scoreboard (R8)
  always @(negedge clk) begin
    if (rstN) begin
      case (consumerMode)
        0: outReady <= 1'b1;
        1: outReady <= ($urandom % 3) != 0;
        default: outReady <= 1'b0;
      endcase
      #1;
      if (outValid && outReady) begin
        if (sbq.size() == 0) chk(1'b0, "R8 unexpected word", {16'h0, outData}, 32'h0);
        else begin
          chk(outData == sbq[0], "R8 word order/value", {16'h0, outData}, {16'h0, sbq[0]});
          void'(sbq.pop_front());
        end
      end
    end
  end

  // channel protocol monitor (R4, R5)
  logic prevReq = 1'b0;
  logic [DATA_W-1:0] prevBus = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (reqLine && prevReq)
        chk(busData == prevBus, "R4 bus stable under request", {16'h0, busData}, {16'h0, prevBus});
      if (reqLine && !prevReq)
        chk(!ackLine, "R5 request rose with ack high", {31'h0, ackLine}, 32'h0);
    end
    prevReq = reqLine;
    prevBus = busData;
  end

  task automatic sendWord(input logic [DATA_W-1:0] w, input int d, input bit timed);
    int cnt;
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = w; dlyCfg = DLY_W'(d);
    sbq.push_back(w);
    @(negedge clk);
    inValid = 1'b0;
    if (timed) begin
      cnt = 0;
      while (!reqLine && cnt < 40) begin @(negedge clk); cnt++; end
      chk(cnt == expDelay(d), "R3 bundling delay", cnt, expDelay(d));
      chk(busData == w, "R4 bus holds word", {16'h0, busData}, {16'h0, w});
      @(negedge clk);
      chk(!ackLine, "R6 ack one cycle after capture (early)", {31'h0, ackLine}, 32'h0);
      @(negedge clk);
      chk(ackLine, "R6 ack raised after capture", {31'h0, ackLine}, 32'h1);
      @(negedge clk);
      chk(!reqLine, "R5 request falls after ack", {31'h0, reqLine}, 32'h0);
      chk(!inReady, "R2 not ready mid-transfer", {31'h0, inReady}, 32'h0);
      @(negedge clk);
      chk(!ackLine, "R7 ack falls after request", {31'h0, ackLine}, 32'h0);
      @(negedge clk);
      chk(inReady && !reqLine && !ackLine, "R2 R7 idle after transfer",
          {29'h0, inReady, reqLine, ackLine}, 32'h4);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (sbq.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    chk(sbq.size() == 0, "R8 all words delivered", sbq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(!reqLine && !ackLine && !outValid && inReady, "R1 reset state",
        {28'h0, reqLine, ackLine, outValid, inReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqLine && !ackLine && !outValid && inReady, "R1 after reset",
        {28'h0, reqLine, ackLine, outValid, inReady}, 32'h1);

    // directed delay corners: R3, R5, R6, R7
    consumerMode = 0;
    sendWord(16'hA5A5, 0, 1'b1);
    sendWord(16'h0001, 1, 1'b1);
    sendWord(16'hFFFF, 3, 1'b1);
    sendWord(16'h1234, 15, 1'b1);
    drain();

    // backpressure stall: R9
    consumerMode = 2;
    repeat (2) @(negedge clk);
    sendWord(16'hBEEF, 2, 1'b0);
    while (!outValid) @(negedge clk);
    sendWord(16'hCAFE, 1, 1'b0);
    repeat (30) @(negedge clk);
    chk(outValid && outData == 16'hBEEF, "R8 held word during stall", {16'h0, outData}, 32'hBEEF);
    chk(reqLine && !ackLine, "R9 receiver ignores request while full",
        {30'h0, reqLine, ackLine}, 32'h2);
    chk(busData == 16'hCAFE, "R4 bus frozen while stalled", {16'h0, busData}, 32'hCAFE);
    consumerMode = 0;
    drain();

    // random traffic
    consumerMode = 1;
    for (int i = 0; i < 60; i++) begin
      sendWord(DATA_W'($urandom), $urandom % 16, 1'b0);
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
    consumerMode = 0;
    repeat (10) @(negedge clk);
    chk(!reqLine && !ackLine && inReady, "R7 lines idle at end",
        {29'h0, reqLine, ackLine, inReady}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule